// File: doc/BRIEF.md
# Vectored Interrupt Collector with Single Outstanding Delivery

This block gathers a large, parameterized set of interrupt lines (1024 by default) and routes each one to one of four vectored outputs. A rising edge on an input line, or a set request written through the configuration port, marks that input pending. Each input has an enable bit and an output-select field. Both are written through the same configuration port.

Every output works on its own. While idle, it walks its share of the pending bits, a fixed slice per cycle. When it finds a deliverable input, it latches that input's number and raises a one-cycle pulse. It then holds that number and stays silent until the core acknowledges it with a clear. The clear drops the input's pending bit, and the output resumes its search. Any remaining work on that output is then delivered with a fresh pulse. A small read port returns, one cycle after an output is selected, the number it presents and whether it presents one.

Top module: `virq_top`

## Requirements
- R1: A rising edge on `irq_in[i]` sets the pending state of input i. A configuration write with `cfg_op` = 2 (set) also sets the pending state of input `cfg_idx`, and `cfg_data` is not used for that operation.
- R2: Configuration writes take effect on the clock edge where `cfg_we` is high. With `cfg_op` = 0, bit 0 of `cfg_data` becomes the enable of input `cfg_idx`. With `cfg_op` = 1, `cfg_data` becomes its output select, where value k routes the input to output k. After reset, every input is disabled and routed to output 0.
- R3: When the pending set of an output has been stable for a full scan, the output presents the lowest-numbered input that is pending, enabled and routed to it. It marks this with a single-cycle high on its `vec_pulse` bit, and the input's pending state is set during that cycle.
- R4: While an output presents a number, it issues no further pulse, and the presented number does not change.
- R5: A clear (`clr_valid` high, `clr_out` = k) while output k presents a number clears that input's pending state and frees the output. If deliverable inputs remain on output k, the next one is presented automatically with a new pulse.
- R6: A disabled input that becomes pending is never presented. It stays pending, and it is presented once it is enabled.
- R7: A clear directed to an output that presents nothing has no effect.
- R8: `rd_num` and `rd_act` return the presented number and the presenting flag of output `rd_sel`. They are registered, so they reflect the `rd_sel` value of the previous cycle.
- R9: After reset, no output pulses and no output presents a number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Interrupt lines, rising-edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 enable, 1 output select, 2 set pending, 3 no operation |
| cfg_idx | input | log2(N_IRQ) | Input number addressed by the write |
| cfg_data | input | log2(N_OUT) | Enable in bit 0, or output select |
| clr_valid | input | 1 | Acknowledge strobe |
| clr_out | input | log2(N_OUT) | Output whose presented interrupt is acknowledged |
| vec_pulse | output | N_OUT | One-cycle delivery pulse per output |
| rd_sel | input | log2(N_OUT) | Output addressed by the read port |
| rd_num | output | log2(N_IRQ) | Presented number of the addressed output |
| rd_act | output | 1 | Addressed output presents a number |

## Verification
The assertions check several rules on every clock. A pulse happens only on the cycle an output starts presenting. The presented number stays fixed while it is held. A clear always frees a presenting output. A pulsing output's input is still pending. Whether the chosen number is really the lowest deliverable one can only be shown by the bench's scenarios. The same holds for whether disabled pending inputs survive until they are enabled, and whether a stray clear leaves state untouched. The bench compares the read port against a reference model of the pending, enable and routing state, using both directed orderings and seeded random bursts.

// File: rtl/virq_pkg.sv
package virq_pkg;
  typedef enum logic [1:0] {
    OP_EN  = 2'd0,
    OP_SEL = 2'd1,
    OP_SET = 2'd2,
    OP_NOP = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/virq_src_bank.sv
module virq_src_bank import virq_pkg::*; #(
  parameter int N_IRQ = 1024,
  parameter int N_OUT = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [N_IRQ-1:0]                     irq_in,
  input  logic                                 cfg_we,
  input  cfg_op_e                              cfg_op,
  input  logic [$clog2(N_IRQ)-1:0]             cfg_idx,
  input  logic [$clog2(N_OUT)-1:0]             cfg_data,
  input  logic                                 clr_en,
  input  logic [$clog2(N_IRQ)-1:0]             clr_idx,
  output logic [N_OUT-1:0][N_IRQ-1:0]          avail,
  output logic [N_IRQ-1:0]                     pend,
  output logic                                 changed
);
  localparam int OSEL_W = $clog2(N_OUT);

  logic [N_IRQ-1:0]            pend_q, pend_d, en_q, prev_q, rise;
  logic [N_OUT-1:0][N_IRQ-1:0] route_q;   // one-hot routing, one plane per output
  logic                        chg_q;

  assign rise = irq_in & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_idx] = 1'b0;
    pend_d = pend_d | rise;
    if (cfg_we && cfg_op == OP_SET) pend_d[cfg_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      en_q    <= '0;
      prev_q  <= '0;
      chg_q   <= 1'b0;
      for (int o = 0; o < N_OUT; o++) route_q[o] <= (o == 0) ? '1 : '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= pend_d;
      chg_q  <= (|rise) || (cfg_we && cfg_op != OP_NOP);
      if (cfg_we && cfg_op == OP_EN) en_q[cfg_idx] <= cfg_data[0];
      if (cfg_we && cfg_op == OP_SEL)
        for (int o = 0; o < N_OUT; o++) route_q[o][cfg_idx] <= (cfg_data == OSEL_W'(o));
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_avail
    assign avail[o] = pend_q & en_q & route_q[o];
  end

  assign pend    = pend_q;
  assign changed = chg_q;
endmodule

// File: rtl/virq_presenter.sv
module virq_presenter #(
  parameter int N_IRQ  = 1024,
  parameter int SCAN_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IRQ-1:0]         avail,
  input  logic                     restart,
  input  logic                     clr_take,
  output logic                     pulse,
  output logic                     pres,
  output logic [$clog2(N_IRQ)-1:0] vec,
  output logic                     clr_hit
);
  localparam int IDX_W = $clog2(N_IRQ);
  localparam int SW_W  = $clog2(SCAN_W);
  localparam int CW    = IDX_W - SW_W;

  logic [CW-1:0]     ptr_q;
  logic [SCAN_W-1:0] chunk;
  logic [SW_W-1:0]   low;
  logic              hit, pulse_q, pres_q;
  logic [IDX_W-1:0]  vec_q;

  assign chunk = avail[{ptr_q, {SW_W{1'b0}}} +: SCAN_W];

  // lowest set bit of the current slice
  always_comb begin
    hit = |chunk;
    low = '0;
    for (int b = SCAN_W - 1; b >= 0; b--)
      if (chunk[b]) low = SW_W'(b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      pulse_q <= 1'b0;
      pres_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (pres_q) begin
        if (clr_take) begin
          pres_q <= 1'b0;
          ptr_q  <= '0;
        end
      end else if (restart) begin
        ptr_q <= '0;
      end else if (hit) begin
        pres_q  <= 1'b1;
        pulse_q <= 1'b1;
        vec_q   <= {ptr_q, low};
        ptr_q   <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign pulse   = pulse_q;
  assign pres    = pres_q;
  assign vec     = vec_q;
  assign clr_hit = clr_take & pres_q;

  AST_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $rose(pres_q)) else $error("pulse without new presentation"); // R4
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
    (pres_q && $past(pres_q)) |-> $stable(vec_q)) else $error("vector moved while held"); // R4
  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pres_q && clr_take) |=> !pres_q) else $error("clear did not free output"); // R5
endmodule

// File: rtl/virq_top.sv
module virq_top import virq_pkg::*; #(
  parameter int N_IRQ  = 1024,
  parameter int N_OUT  = 4,
  parameter int SCAN_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_IRQ-1:0]           irq_in,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_op,
  input  logic [$clog2(N_IRQ)-1:0]   cfg_idx,
  input  logic [$clog2(N_OUT)-1:0]   cfg_data,
  input  logic                       clr_valid,
  input  logic [$clog2(N_OUT)-1:0]   clr_out,
  output logic [N_OUT-1:0]           vec_pulse,
  input  logic [$clog2(N_OUT)-1:0]   rd_sel,
  output logic [$clog2(N_IRQ)-1:0]   rd_num,
  output logic                       rd_act
);
  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int OSEL_W = $clog2(N_OUT);

  logic [N_OUT-1:0][N_IRQ-1:0] avail_w;
  logic [N_IRQ-1:0]            pend_w;
  logic                        changed_w, clr_en;
  logic [N_OUT-1:0]            pres_w, clr_hit_w, pulse_w;
  logic [IDX_W-1:0]            vec_w [N_OUT];
  logic [IDX_W-1:0]            rd_num_q;
  logic                        rd_act_q;

  virq_src_bank #(.N_IRQ(N_IRQ), .N_OUT(N_OUT)) u_bank (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_op(cfg_op_e'(cfg_op)), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .clr_en(clr_en), .clr_idx(vec_w[clr_out]),
    .avail(avail_w), .pend(pend_w), .changed(changed_w)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    virq_presenter #(.N_IRQ(N_IRQ), .SCAN_W(SCAN_W)) u_pres (
      .clk(clk), .rst(rst), .avail(avail_w[o]), .restart(changed_w),
      .clr_take(clr_valid && clr_out == OSEL_W'(o)),
      .pulse(pulse_w[o]), .pres(pres_w[o]), .vec(vec_w[o]), .clr_hit(clr_hit_w[o])
    );

    AST_PULSE_PENDING: assert property (@(posedge clk) disable iff (rst)
      pulse_w[o] |-> pend_w[vec_w[o]]) else $error("pulsed input not pending"); // R3
  end

  assign clr_en    = |clr_hit_w;
  assign vec_pulse = pulse_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_num_q <= '0;
      rd_act_q <= 1'b0;
    end else begin
      rd_num_q <= vec_w[rd_sel];
      rd_act_q <= pres_w[rd_sel];
    end
  end

  assign rd_num = rd_num_q;
  assign rd_act = rd_act_q;
endmodule

// File: tb/sim_virq_top.sv
module sim_virq_top;
  localparam int N  = 1024;
  localparam int NO = 4;
  localparam int IW = $clog2(N);
  localparam int OW = $clog2(NO);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_op = 2'd3;
  logic [IW-1:0] cfg_idx = '0;
  logic [OW-1:0] cfg_data = '0;
  logic          clr_valid = 1'b0;
  logic [OW-1:0] clr_out = '0;
  logic [NO-1:0] vec_pulse;
  logic [OW-1:0] rd_sel = '0;
  logic [IW-1:0] rd_num;
  logic          rd_act;

  always #10 clk = ~clk;  // 50 MHz

  virq_top u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit m_pend [N];
  bit m_en [N];
  int m_sel [N];
  int pcnt [NO];
  int taken [NO];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk)
    if (!rst)
      for (int o = 0; o < NO; o++) if (vec_pulse[o]) pcnt[o]++;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  function automatic int exp_of(input int o);
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && m_sel[i] == o) return i;
    return -1;
  endfunction

  task automatic cfg(input int op, input int idx, input int data);
    cfg_we = 1'b1; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_data = OW'(data);
    @(negedge clk);
    cfg_we = 1'b0; cfg_op = 2'd3;
    if (op == 0) m_en[idx] = data[0];
    else if (op == 1) m_sel[idx] = data;
    else if (op == 2) m_pend[idx] = 1'b1;
  endtask

  task automatic clr(input int o);
    clr_valid = 1'b1; clr_out = OW'(o);
    @(negedge clk);
    clr_valid = 1'b0;
  endtask

  task automatic rd(input int o, output bit act, output int num);
    rd_sel = OW'(o);
    @(negedge clk);
    act = rd_act; num = int'(rd_num);
  endtask

  task automatic fire(input logic [N-1:0] v);
    irq_in = v;
    @(negedge clk);
    irq_in = '0;
    for (int i = 0; i < N; i++) if (v[i]) m_pend[i] = 1'b1;
  endtask

  // wait for output o to present, compare with the model, check the hold, then clear
  task automatic present_check(input int o, input string req);
    int e, num, n0;
    bit act;
    e = exp_of(o);
    act = 1'b0; num = 0;
    for (int t = 0; t < 200 && !act; t++) rd(o, act, num);
    chk(act == 1'b1, {req, " presented"}, int'(act), 1);
    chk(num == e, {req, " lowest number"}, num, e);
    chk(pcnt[o] == taken[o] + 1, {req, " single pulse"}, pcnt[o], taken[o] + 1);
    n0 = pcnt[o];
    repeat (40) @(negedge clk);
    rd(o, act, num);
    chk(pcnt[o] == n0 && num == e, "R4 held without repulse", pcnt[o] * 10000 + num, n0 * 10000 + e);
    taken[o] = pcnt[o];
    clr(o);
    if (e >= 0) m_pend[e] = 1'b0;
  endtask

  initial begin
    bit act;
    int num;
    logic [N-1:0] v;
    void'($urandom(32'h1e5c_0a7b));
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_en[i] = 0; m_sel[i] = 0; end
    for (int o = 0; o < NO; o++) begin pcnt[o] = 0; taken[o] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    for (int o = 0; o < NO; o++) begin
      rd(o, act, num);
      chk(act == 1'b0, "R9 idle after reset", int'(act), 0);
    end
    repeat (50) @(negedge clk);
    chk(pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] == 0, "R9 no pulse after reset", pcnt[0], 0);

    // R1 software set, R2 default routing to output 0
    cfg(0, 5, 1);
    cfg(2, 5, 3);
    present_check(0, "R1 R2 soft set");

    // R8 read port latency
    cfg(2, 5, 0);
    repeat (80) @(negedge clk);
    rd(1, act, num);
    chk(act == 1'b0, "R8 idle output reads inactive", int'(act), 0);
    rd(0, act, num);
    chk(act == 1'b1 && num == 5, "R8 read follows rd_sel", num, 5);
    present_check(0, "R8 re-present");

    // R6 disabled pending held back, R7 stray clear ignored
    cfg(1, 700, 3);
    cfg(2, 700, 0);
    repeat (100) @(negedge clk);
    rd(3, act, num);
    chk(act == 1'b0, "R6 disabled input not presented", int'(act), 0);
    chk(pcnt[3] == 0, "R6 no pulse for disabled input", pcnt[3], 0);
    clr(3);
    repeat (5) @(negedge clk);
    cfg(0, 700, 1);
    present_check(3, "R6 R7 pending kept");

    // R3 R5 ordering from simultaneous edges
    cfg(1, 900, 1); cfg(0, 900, 1);
    cfg(1, 300, 1); cfg(0, 300, 1);
    cfg(1, 40, 1);  cfg(0, 40, 1);
    v = '0; v[900] = 1'b1; v[300] = 1'b1; v[40] = 1'b1;
    fire(v);
    chk(exp_of(1) == 40, "R1 edges pend model", exp_of(1), 40);
    present_check(1, "R3 first of three");
    present_check(1, "R5 second of three");
    present_check(1, "R5 third of three");

    // randomized bursts
    for (int r = 0; r < 6; r++) begin
      v = '0;
      for (int k = 0; k < 10; k++) begin
        int idx;
        idx = int'($urandom % N);
        if (!m_pend[idx]) begin
          cfg(0, idx, ($urandom % 4) != 0 ? 1 : 0);
          cfg(1, idx, int'($urandom % NO));
          v[idx] = 1'b1;
        end
      end
      fire(v);
      for (int it = 0; it < 20; it++) begin
        bit any;
        any = 1'b0;
        for (int o = 0; o < NO; o++)
          if (exp_of(o) >= 0) begin
            any = 1'b1;
            present_check(o, "R3 R5 random");
          end
        if (!any) break;
      end
      repeat (80) @(negedge clk);
      for (int o = 0; o < NO; o++) begin
        rd(o, act, num);
        chk(act == 1'b0, "R6 only disabled left", int'(act), 0);
      end
    end
    report();
  end
endmodule